// File: doc/BRIEF.md
# BCD-Programmed Frequency Divider

This block divides a fast input clock by a programmable ratio for the feedback path of a frequency synthesizer. The ratio N is given as three BCD digits (hundreds, tens, units), which allows 1 to 999. A fixed prescaler of 1, 2, 4 or 10 sits ahead of the digit chain. Three synchronous decade stages count prescaler ticks and carry into one another. When every stage matches its digit of N−1, the block emits a one-cycle pulse on `div_out`. On the same edge all stages and the prescaler go back to zero. The total ratio is therefore prescale × N input clocks per output pulse.

Software pulses `load` for one clock together with the digits and the prescale code. A valid setting is held pending. It becomes active on the edge that ends the current output period, so no period is ever cut short or stretched. A setting with a digit above 9, or with N equal to zero, is refused. The active and pending settings are then left as they were, and `bad_setting` is raised. It stays high until a valid load arrives.

Top module: `bcd_ratio_divider`

## Requirements
- R1: While `rst_n` is low, `div_out` and `bad_setting` are 0. After reset the active setting is N=1 with prescale 1, so `div_out` is high on every clock.
- R2: With prescale code 00 (divide by 1), a setting with digits hundreds/tens/units gives one `div_out` pulse every N = 100·hi + 10·mid + lo input clocks.
- R3: Prescale code 00 divides by 1, 01 by 2, 10 by 4 and 11 by 10. The output period is the prescale value × N clocks. The code is captured together with the digits by `load`.
- R4: Carries between decades are synchronous and exact, including settings whose N−1 borrows across digits (N=100) and the largest setting (N=999).
- R5: When prescale × N ≥ 2, each `div_out` pulse lasts exactly one clock.
- R6: A valid load takes effect only at the end of the current output period. A load made mid-period leaves the length of that period unchanged.
- R7: A load with any digit above 9 is refused. The previous setting stays in force and `bad_setting` is 1 from the clock after the load.
- R8: A load with all three digits 0 is refused in the same way as R7.
- R9: `bad_setting` stays 1 until the next accepted load, which clears it on the clock after that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock taken from the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 2 | Prescale code: 00=/1, 01=/2, 10=/4, 11=/10 |
| dig_hi | input | 4 | BCD hundreds digit of N |
| dig_mid | input | 4 | BCD tens digit of N |
| dig_lo | input | 4 | BCD units digit of N |
| load | input | 1 | One-clock strobe that captures psel and the digits |
| div_out | output | 1 | One-clock pulse per prescale × N input clocks |
| bad_setting | output | 1 | High after a refused load, until the next accepted load |

## Verification
The hardest case to reach is a load that arrives in the middle of a long period. If the new setting were applied at once, the period in progress would end early. The bench synchronises to a pulse of a 200-clock setting, loads a 30-clock setting 50 clocks later, and counts the clocks to the next pulse, which must still be 200. It then counts the following period, which must be 30. Refused loads are checked the same way: the bench measures the period again after `bad_setting` rises, to show the old ratio is still in force.

// File: rtl/bcd_ratio_divider.sv
module bcd_ratio_divider (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic [1:0] psel,
  input  logic [3:0] dig_hi,
  input  logic [3:0] dig_mid,
  input  logic [3:0] dig_lo,
  input  logic       load,
  output logic       div_out,
  output logic       bad_setting
);

  logic [11:0] cnt, act_t, pend_t, new_t;
  logic [1:0]  act_ps, pend_ps;
  logic        pend_v;
  logic [3:0]  pcnt, plim;
  logic        tick, term, set_ok;

  assign set_ok = (dig_hi <= 4'd9) && (dig_mid <= 4'd9) && (dig_lo <= 4'd9)
                  && (|{dig_hi, dig_mid, dig_lo});

  // BCD decrement of the requested ratio: the terminal count is N-1
  always_comb begin
    new_t = {dig_hi, dig_mid, dig_lo};
    if (dig_lo != 4'd0) begin
      new_t[3:0] = dig_lo - 4'd1;
    end else begin
      new_t[3:0] = 4'd9;
      if (dig_mid != 4'd0) begin
        new_t[7:4] = dig_mid - 4'd1;
      end else begin
        new_t[7:4]  = 4'd9;
        new_t[11:8] = dig_hi - 4'd1;
      end
    end
  end

  always_comb begin
    case (act_ps)
      2'd0:    plim = 4'd0;
      2'd1:    plim = 4'd1;
      2'd2:    plim = 4'd3;
      default: plim = 4'd9;
    endcase
  end

  assign tick = (pcnt == plim);
  assign term = tick && (cnt == act_t);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      pcnt        <= '0;
      div_out     <= 1'b0;
      act_t       <= '0;
      act_ps      <= '0;
      pend_t      <= '0;
      pend_ps     <= '0;
      pend_v      <= 1'b0;
      bad_setting <= 1'b0;
    end else begin
      div_out <= term;
      if (term) begin
        cnt  <= '0;
        pcnt <= '0;
        if (pend_v) begin
          act_t  <= pend_t;
          act_ps <= pend_ps;
          pend_v <= 1'b0;
        end
      end else begin
        pcnt <= tick ? 4'd0 : pcnt + 4'd1;
        if (tick) begin
          if (cnt[3:0] != 4'd9) begin
            cnt[3:0] <= cnt[3:0] + 4'd1;
          end else begin
            cnt[3:0] <= 4'd0;
            if (cnt[7:4] != 4'd9) begin
              cnt[7:4] <= cnt[7:4] + 4'd1;
            end else begin
              cnt[7:4]  <= 4'd0;
              cnt[11:8] <= (cnt[11:8] == 4'd9) ? 4'd0 : cnt[11:8] + 4'd1;
            end
          end
        end
      end
      if (load) begin
        if (set_ok) begin
          pend_t      <= new_t;
          pend_ps     <= psel;
          pend_v      <= 1'b1;
          bad_setting <= 1'b0;
        end else begin
          bad_setting <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bcd_ratio_divider_chk.sv
module bcd_ratio_divider_chk (
  input logic        clk_in,
  input logic        rst_n,
  input logic        load,
  input logic        set_ok,
  input logic        tick,
  input logic        div_out,
  input logic        bad_setting,
  input logic [11:0] cnt,
  input logic [11:0] act_t,
  input logic [11:0] pend_t,
  input logic [1:0]  act_ps
);

  // R4
  digit_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt[3:0] <= 4'd9) && (cnt[7:4] <= 4'd9) && (cnt[11:8] <= 4'd9));

  // R4
  hold_without_tick_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!tick && !div_out) |=> ($stable(cnt) || div_out));

  // R1
  restart_on_pulse_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    div_out |-> (cnt == 12'd0));

  // R6
  swap_at_end_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !($stable(act_t) && $stable(act_ps)) |-> div_out);

  // R7
  refuse_keeps_pending_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (load && !set_ok) |=> ($stable(pend_t) && bad_setting));

  // R9
  flag_needs_load_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(bad_setting) |-> $past(load));

endmodule

bind bcd_ratio_divider bcd_ratio_divider_chk u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .load(load), .set_ok(set_ok), .tick(tick),
  .div_out(div_out), .bad_setting(bad_setting), .cnt(cnt), .act_t(act_t),
  .pend_t(pend_t), .act_ps(act_ps)
);

// File: tb/tb_bcd_ratio_divider.sv
module tb_bcd_ratio_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] psel = '0;
  logic [3:0] dig_hi = '0, dig_mid = '0, dig_lo = '0;
  logic load = 1'b0;
  logic div_out, bad_setting;
  int tests = 0, fails = 0, cyc = 0;

  bcd_ratio_divider dut (
    .clk_in(clk), .rst_n(rst_n), .psel(psel), .dig_hi(dig_hi), .dig_mid(dig_mid),
    .dig_lo(dig_lo), .load(load), .div_out(div_out), .bad_setting(bad_setting)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    @(negedge clk);
    while (!div_out) @(negedge clk);
  endtask

  task automatic period(output int n);
    n = 1;
    @(negedge clk);
    while (!div_out) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_load(input logic [1:0] p, input int h, input int m, input int l);
    @(negedge clk);
    psel = p; dig_hi = 4'(h); dig_mid = 4'(m); dig_lo = 4'(l); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic set_and_measure(string req, input logic [1:0] p, input int h,
                                 input int m, input int l, input int exp);
    int n;
    do_load(p, h, m, l);
    wait_pulse();
    wait_pulse();
    period(n);
    check(req, n, exp);
  endtask

  task automatic t_reset();
    int n;
    check("R1 div_out in reset", int'(div_out), 0);
    check("R1 bad_setting in reset", int'(bad_setting), 0);
    @(negedge clk); rst_n = 1'b1;
    wait_pulse();
    period(n);
    check("R1 default ratio", n, 1);
  endtask

  task automatic t_ratios();
    set_and_measure("R2 N=123", 2'b00, 1, 2, 3, 123);
    set_and_measure("R2 N=7", 2'b00, 0, 0, 7, 7);
    set_and_measure("R4 N=100 borrow", 2'b00, 1, 0, 0, 100);
    set_and_measure("R4 N=999", 2'b00, 9, 9, 9, 999);
    set_and_measure("R4 N=10", 2'b00, 0, 1, 0, 10);
  endtask

  task automatic t_prescale();
    set_and_measure("R3 /2 N=50", 2'b01, 0, 5, 0, 100);
    set_and_measure("R3 /4 N=7", 2'b10, 0, 0, 7, 28);
    set_and_measure("R3 /10 N=880", 2'b11, 8, 8, 0, 8800);
    set_and_measure("R3 /10 N=1", 2'b11, 0, 0, 1, 10);
  endtask

  task automatic t_width();
    set_and_measure("R5 /2 N=1", 2'b01, 0, 0, 1, 2);
    wait_pulse();
    @(negedge clk);
    check("R5 pulse one clock", int'(div_out), 0);
  endtask

  task automatic t_midcount();
    int n;
    set_and_measure("R6 base N=200", 2'b00, 2, 0, 0, 200);
    wait_pulse();
    n = 0;
    repeat (49) begin @(negedge clk); n++; end
    psel = 2'b00; dig_hi = 4'd0; dig_mid = 4'd3; dig_lo = 4'd0; load = 1'b1;
    @(negedge clk); n++;
    load = 1'b0;
    while (!div_out) begin @(negedge clk); n++; end
    check("R6 current period kept", n, 200);
    period(n);
    check("R6 new period after end", n, 30);
  endtask

  task automatic t_refuse();
    int n;
    set_and_measure("R7 base N=25", 2'b00, 0, 2, 5, 25);
    do_load(2'b00, 0, 12, 0);
    check("R7 flag after bad digit", int'(bad_setting), 1);
    wait_pulse(); wait_pulse();
    period(n);
    check("R7 old ratio kept", n, 25);
    check("R9 flag held", int'(bad_setting), 1);
    do_load(2'b00, 0, 0, 4);
    check("R9 flag cleared", int'(bad_setting), 0);
    wait_pulse(); wait_pulse();
    period(n);
    check("R9 accepted ratio", n, 4);
    do_load(2'b01, 0, 0, 0);
    check("R8 flag after zero", int'(bad_setting), 1);
    wait_pulse(); wait_pulse();
    period(n);
    check("R8 old ratio kept", n, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ratios();
    t_prescale();
    t_width();
    t_midcount();
    t_refuse();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule